// File: doc/BRIEF.md
# Eight-Channel Driver Fault Protection Controller

This block decides, cycle by cycle, which of eight output drivers must be forced off. Each channel has its own overcurrent sense bit. A sense bit has to stay active for a qualification window before it latches that channel off. The window is set in nanoseconds and turned into a clock-cycle count from a clock-frequency parameter. A sense pulse that drops before the window ends restarts the count and has no effect. A latched channel stays off until the shared enable/reset pin is driven high or power-on reset is applied. Other channels are not affected.

Two global conditions turn every channel off: an over-temperature flag and an undervoltage-lockout flag. Neither is latched. Both pass through a two-flop synchronizer, and the channels come back by themselves two clock edges after the flag clears. The synchronizers reset to the "fault present" state, so all channels stay off while reset is applied. The output is an inhibit vector that the output stage uses to gate its drivers.

Top module: `drv_fault_ctrl`

## Requirements
- R1: While rst_n is low, inhibit_o is 8'hFF. With both global flags low, inhibit_o is 8'h00 from the second rising edge after reset is released.
- R2: The qualification count QUAL is ceil(QUAL_NS × CLK_HZ / 10^9) cycles, which is 500 at the defaults. A sense bit that is high on only QUAL-1 consecutive rising edges never sets that channel's inhibit bit.
- R3: On the QUAL-th consecutive rising edge with oc_sense_i[n] high, inhibit_o[n] becomes 1. It stays 1 after the sense bit drops.
- R4: An overcurrent fault on channel n sets only inhibit_o[n]. Bit n of the vector belongs to channel n.
- R5: One rising edge with the sense bit low restarts that channel's count from zero.
- R6: While en_rst_i is high, every latched overcurrent fault is clear from the next rising edge on, even with sense bits held high.
- R7: A sense bit that stays high through an en_rst_i pulse longer than the window latches again on the first rising edge after en_rst_i falls.
- R8: therm_i high sets all eight inhibit bits two rising edges later. Clearing it releases them two edges later, and latched overcurrent faults survive.
- R9: uvlo_i behaves as in R8. It is independent of therm_i and does not latch.
- R10: inhibit_o[n] is the OR of channel n's latched fault and the synchronized therm_i and uvlo_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| oc_sense_i | input | 8 | Per-channel overcurrent sense, active high, synchronous to clk |
| therm_i | input | 1 | Over-temperature flag, asynchronous |
| uvlo_i | input | 1 | Undervoltage-lockout flag, asynchronous |
| en_rst_i | input | 1 | Enable/reset pin, a high level clears latched faults |
| inhibit_o | output | 8 | Per-channel driver inhibit, 1 forces the channel off |

## Verification
The bench drives sense pulses one cycle short of the window and exactly at the window. A design with an off-by-one counter would either latch on the short pulse or miss the exact one. A single low cycle in the middle of a long pulse exposes a count that pauses instead of restarting. Holding a sense bit high through a long reset pulse shows whether the design forgets the still-present fault or fails to release during reset. Global flag tests carry a latched fault through a thermal or UVLO episode, which catches a design that lets global flags wipe per-channel latches or that drops the synchronizer delay.

// File: rtl/dfp_pkg.sv
`timescale 1ns/1ps
package dfp_pkg;

  // Qualification window in cycles, rounded up so a pulse is never
  // accepted below the window; at least one cycle.
  function automatic int unsigned qual_cycles(input longint unsigned clk_hz,
                                              input longint unsigned win_ns);
    longint unsigned prod;
    longint unsigned cyc;
    prod = clk_hz * win_ns;
    cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc == 0) cyc = 1;
    return int'(cyc);
  endfunction

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/dfp_sync2.sv
`timescale 1ns/1ps
module dfp_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {2{RST_VAL}};
    else        stage_q <= {stage_q[0], d_i};
  end

  assign q_o = stage_q[1];

endmodule

// File: rtl/dfp_oc_chan.sv
`timescale 1ns/1ps
module dfp_oc_chan #(
  parameter int unsigned QUAL  = 500,
  parameter int unsigned CNT_W = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sense_i,
  input  logic clr_i,
  output logic qual_hit_o,
  output logic fault_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL - 1);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(QUAL);

  logic [CNT_W-1:0] run_q;
  logic             fault_q;

  // Sense seen high on QUAL consecutive edges counting this one.
  assign qual_hit_o = sense_i && (run_q >= LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (!sense_i)   run_q <= '0;
    else if (run_q != SAT) run_q <= run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fault_q <= 1'b0;
    else if (clr_i)      fault_q <= 1'b0;
    else if (qual_hit_o) fault_q <= 1'b1;
  end

  assign fault_o = fault_q;

endmodule

// File: rtl/drv_fault_ctrl.sv
`timescale 1ns/1ps
module drv_fault_ctrl #(
  parameter int unsigned NUM_CH = 8,
  parameter longint unsigned CLK_HZ = 250_000_000,
  parameter longint unsigned QUAL_NS = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] oc_sense_i,
  input  logic              therm_i,
  input  logic              uvlo_i,
  input  logic              en_rst_i,
  output logic [NUM_CH-1:0] inhibit_o
);

  import dfp_pkg::*;

  localparam int unsigned QUAL  = qual_cycles(CLK_HZ, QUAL_NS);
  localparam int unsigned CNT_W = cnt_width(QUAL);

  // Named internal events for the checker.
  logic              therm_s;
  logic              uvlo_s;
  logic [NUM_CH-1:0] qual_hit;
  logic [NUM_CH-1:0] fault_q;
  logic              global_off;

  dfp_sync2 #(.RST_VAL(1'b1)) u_therm_sync (
    .clk(clk), .rst_n(rst_n), .d_i(therm_i), .q_o(therm_s)
  );

  dfp_sync2 #(.RST_VAL(1'b1)) u_uvlo_sync (
    .clk(clk), .rst_n(rst_n), .d_i(uvlo_i), .q_o(uvlo_s)
  );

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
      dfp_oc_chan #(.QUAL(QUAL), .CNT_W(CNT_W)) u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .sense_i   (oc_sense_i[ch]),
        .clr_i     (en_rst_i),
        .qual_hit_o(qual_hit[ch]),
        .fault_o   (fault_q[ch])
      );
    end
  endgenerate

  assign global_off = therm_s | uvlo_s;
  assign inhibit_o  = fault_q | {NUM_CH{global_off}};

endmodule

// File: rtl/dfp_fault_chk.sv
`timescale 1ns/1ps
module dfp_fault_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned QUAL   = 500
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] oc_sense_i,
  input logic              en_rst_i,
  input logic              therm_s,
  input logic              uvlo_s,
  input logic [NUM_CH-1:0] fault_q,
  input logic [NUM_CH-1:0] inhibit_o
);

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_chk
      int unsigned run_len;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 run_len <= 0;
        else if (!oc_sense_i[ch])   run_len <= 0;
        else if (run_len < QUAL)    run_len <= run_len + 1;
      end

      // R2: a fault latches only after a full qualification run.
      p_glitch_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_q[ch]) |-> (run_len >= QUAL));

      // R3: a latched fault holds while reset is not requested.
      p_fault_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q[ch] && !en_rst_i) |=> fault_q[ch]);

      // R10: a channel inhibit without a global flag must come from its own latch.
      p_chan_isolated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_o[ch] && !therm_s && !uvlo_s) |-> fault_q[ch]);
    end
  endgenerate

  // R6: reset level clears every latch on the next edge.
  p_reset_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_rst_i |=> (fault_q == '0));

  // R8: synchronized thermal flag forces every channel off.
  p_thermal_all_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    therm_s |-> (&inhibit_o));

  // R9: synchronized lockout flag forces every channel off.
  p_uvlo_all_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_s |-> (&inhibit_o));

endmodule

bind drv_fault_ctrl dfp_fault_chk #(.NUM_CH(NUM_CH), .QUAL(QUAL)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .oc_sense_i(oc_sense_i),
  .en_rst_i  (en_rst_i),
  .therm_s   (therm_s),
  .uvlo_s    (uvlo_s),
  .fault_q   (fault_q),
  .inhibit_o (inhibit_o)
);

// File: tb/drv_fault_ctrl_tb_top.sv
`timescale 1ns/1ps
module drv_fault_ctrl_tb_top;

  localparam int CLK_NS = 4;
  localparam int WIN_NS = 2000;
  localparam int Q      = WIN_NS / CLK_NS;   // 500 cycles at 250 MHz

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] oc_sense = '0;
  logic       therm = 1'b0;
  logic       uvlo = 1'b0;
  logic       en_rst = 1'b0;
  logic [7:0] inhibit;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  drv_fault_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .oc_sense_i(oc_sense), .therm_i(therm),
    .uvlo_i(uvlo), .en_rst_i(en_rst), .inhibit_o(inhibit)
  );

  // Reference state, built from the requirements.
  int         m_run [8];
  logic [7:0] m_fault;
  logic [1:0] m_th, m_uv;

  function automatic logic [7:0] exp_of(input logic [7:0] f, input logic th,
                                        input logic uv);
    return (th || uv) ? 8'hFF : f;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_th <= 2'b11; m_uv <= 2'b11; m_fault <= '0;
      for (int c = 0; c < 8; c++) m_run[c] <= 0;
    end else begin
      m_th <= {m_th[0], therm};
      m_uv <= {m_uv[0], uvlo};
      for (int c = 0; c < 8; c++) begin
        int nrun;
        nrun = oc_sense[c] ? ((m_run[c] >= Q) ? Q : m_run[c] + 1) : 0;
        m_run[c] <= nrun;
        if (en_rst)          m_fault[c] <= 1'b0;
        else if (nrun >= Q)  m_fault[c] <= 1'b1;
      end
    end
  end

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (inhibit !== exp) begin
      n_fail++;
      $display("FAIL %s: inhibit=%h expected=%h at %0t", req, inhibit, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * CLK_NS);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // R1: reset state and release
    cyc(3);
    check("R1 reset", 8'hFF);
    rst_n = 1'b1;
    cyc(1);
    check("R1 sync delay", 8'hFF);
    cyc(1);
    check("R1 release", 8'h00);

    // R2: one cycle short of the window
    oc_sense[0] = 1'b1;
    cyc(Q - 1);
    oc_sense[0] = 1'b0;
    cyc(2);
    check("R2 short pulse", 8'h00);

    // R3 / R4: exact window on channel 2
    oc_sense[2] = 1'b1;
    cyc(Q - 1);
    check("R2 boundary", 8'h00);
    cyc(1);
    check("R3 latch", 8'h04);
    oc_sense[2] = 1'b0;
    cyc(5);
    check("R3 held", 8'h04);
    check("R4 isolation", 8'h04);

    // R5: one low cycle restarts the count
    oc_sense[5] = 1'b1;
    cyc(Q - 1);
    oc_sense[5] = 1'b0;
    cyc(1);
    oc_sense[5] = 1'b1;
    cyc(Q - 1);
    check("R5 restart", 8'h04);
    cyc(1);
    check("R5 full run", 8'h24);
    oc_sense[5] = 1'b0;

    // R6 / R7: reset level clears and holds clear, relatch after release
    en_rst = 1'b1;
    cyc(1);
    check("R6 clear", 8'h00);
    oc_sense[1] = 1'b1;
    cyc(Q + 5);
    check("R6 held clear", 8'h00);
    en_rst = 1'b0;
    cyc(1);
    check("R7 relatch", 8'h02);
    oc_sense[1] = 1'b0;
    en_rst = 1'b1;
    cyc(1);
    en_rst = 1'b0;
    check("R6 pulse", 8'h00);

    // R8: thermal episode over a latched fault
    oc_sense[7] = 1'b1;
    cyc(Q);
    oc_sense[7] = 1'b0;
    check("R3 ch7", 8'h80);
    therm = 1'b1;
    cyc(1);
    check("R8 delay", 8'h80);
    cyc(1);
    check("R8 all off", 8'hFF);
    therm = 1'b0;
    cyc(1);
    check("R8 release delay", 8'hFF);
    cyc(1);
    check("R8 fault kept", 8'h80);

    // R9: lockout episode
    uvlo = 1'b1;
    cyc(2);
    check("R9 all off", 8'hFF);
    uvlo = 1'b0;
    cyc(2);
    check("R9 release", 8'h80);
    en_rst = 1'b1;
    cyc(1);
    en_rst = 1'b0;
    check("R6 final clear", 8'h00);

    // R10: random mix against the reference state
    for (int i = 0; i < 20000; i++) begin
      cyc(1);
      check("R10 random", exp_of(m_fault, m_th[1], m_uv[1]));
      for (int c = 0; c < 8; c++)
        if ($urandom_range(0, 399) == 0) oc_sense[c] = ~oc_sense[c];
      en_rst = ($urandom_range(0, 299) == 0);
      if ($urandom_range(0, 199) == 0) therm = ~therm;
      if ($urandom_range(0, 199) == 0) uvlo = ~uvlo;
    end
    finish_run();
  end

endmodule